// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This block sits between a 32-bit processor result bus and a 32-bit peripheral data bus made of four 8-bit byte lanes. The address space is byte addressable. An access is a byte, a 16-bit halfword or a 32-bit word.

On a store, the unit copies the low-order processor data up onto the lanes chosen by the two low address bits. On a load, it moves the addressed lane or lanes down to bit 0 and then sign- or zero-extends the result. It also drives one strobe per lane that marks the lanes the access touches.

Alignment is done with a small fixed set of lane-to-lane copy paths, not with a barrel shifter. Some paths feed others: a byte at offset 3 is stored through lane 1, and loaded back through lane 1. The steering controls and both data operands are captured on a one-cycle `start` pulse. The outputs are produced from those registers and hold until the next pulse.

Top module: `lane_align_unit`

## Requirements
- R1: Encodings: `size` 2'b00 = byte, 2'b01 = halfword, 2'b10 = word, 2'b11 = reserved. Lane i occupies bits [8i+7:8i]. `byte_sel[i]` is 1 in any of three cases: a byte access with `addr_lo` equal to i; a halfword access with `addr_lo[1]` equal to bit 1 of i; a word access.
- R2: On a store (`is_store`=1), each lane selected by `byte_sel` carries the processor data shifted left by 8 × `addr_lo`. This includes a byte at offset 3, which is routed through lane 1.
- R3: On a byte load, `cpu_rdata[7:0]` is lane `addr_lo` of `bus_rdata`. Bits [31:8] copy bit 7 when `signed_ld`=1 and are zero otherwise.
- R4: On a halfword load at offset 0 or 2, `cpu_rdata[15:0]` is the addressed halfword of `bus_rdata`. Bits [31:16] copy bit 15 when `signed_ld`=1 and are zero otherwise.
- R5: A word access ignores `addr_lo` and `signed_ld`. On a store the data passes through unchanged, and on a load it comes back unchanged. All four lanes are selected and `misalign` is 0.
- R6: Copy paths are gated by direction. After a load, `bus_wdata` equals the captured `cpu_wdata` unchanged.
- R7: A halfword with `addr_lo[0]`=1, or a reserved size, sets `misalign`=1 and drives `byte_sel`=4'b0000. Any other access leaves `misalign`=0.
- R8: Outputs update only at a rising edge where `start`=1. With `start`=0 they hold, whatever the other inputs do.
- R9: Synchronous active-high `rst` forces all outputs to zero: no lane selected, no copy path enabled, no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for one access |
| is_store | input | 1 | 1 = store, 0 = load |
| size | input | 2 | Access size code (R1) |
| addr_lo | input | 2 | Byte offset within the word |
| signed_ld | input | 1 | Sign-extend narrow loads |
| cpu_wdata | input | 32 | Processor result bus (store data) |
| bus_rdata | input | 32 | Peripheral data bus (load data) |
| bus_wdata | output | 32 | Lane-steered store data |
| cpu_rdata | output | 32 | Aligned and extended load data |
| byte_sel | output | 4 | Per-lane strobes |
| misalign | output | 1 | Illegal size/offset combination |

## Verification
Every result of an access is due after the first rising edge at which `start` is sampled high. There is no further pipeline stage: the strobes, the error flag and both data buses settle in that same cycle. The bench drives each access on a falling edge, raises `start` for exactly one cycle, and samples all outputs on the next falling edge. To check that results hold, it keeps `start` low for one more cycle while scrambling the inputs, then samples again on the following falling edge and expects unchanged values.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  localparam int NUM_LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // Steering controls; all-zero means word pass-through with no copy path.
  typedef struct packed {
    logic                 st_l1_from_l0;
    logic                 st_l2_from_l0;
    logic                 st_l3_from_l1;
    logic                 ld_l0_from_l1;
    logic                 ld_l0_from_l2;
    logic                 ld_l1_from_l3;
    logic                 ext_byte;
    logic                 ext_half;
    logic                 ext_signed;
    logic [NUM_LANES-1:0] lane_en;
    logic                 fault;
  } steer_ctrl_t;
endpackage

// File: rtl/lane_ctrl_decode.sv
module lane_ctrl_decode
  import lane_align_pkg::*;
(
  input  logic        is_store,
  input  acc_size_e   size,
  input  logic [1:0]  addr_lo,
  input  logic        signed_ld,
  output steer_ctrl_t ctrl
);
  logic is_b, is_h, is_w, bad, at2, at3;

  always_comb begin
    is_b = (size == SZ_BYTE);
    is_h = (size == SZ_HALF);
    is_w = (size == SZ_WORD);
    bad  = (size == SZ_RSVD) || (is_h && addr_lo[0]);
    at2  = (addr_lo == 2'd2);
    at3  = (addr_lo == 2'd3);
  end

  // Per-lane strobes
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane_en
    localparam logic [1:0] LANE_IDX = 2'(i);
    assign ctrl.lane_en[i] = !bad &&
      ((is_b && addr_lo == LANE_IDX) ||
       (is_h && addr_lo[1] == LANE_IDX[1]) ||
       is_w);
  end

  // Store copy paths (upward), chained for offset 3
  assign ctrl.st_l1_from_l0 = !bad && is_store && is_b && addr_lo[0];
  assign ctrl.st_l2_from_l0 = !bad && is_store && (is_b || is_h) && at2;
  assign ctrl.st_l3_from_l1 = !bad && is_store && ((is_b && at3) || (is_h && addr_lo[1]));

  // Load copy paths (downward), chained for offset 3
  assign ctrl.ld_l0_from_l1 = !bad && !is_store && is_b && addr_lo[0];
  assign ctrl.ld_l0_from_l2 = !bad && !is_store && (is_b || is_h) && at2;
  assign ctrl.ld_l1_from_l3 = !bad && !is_store && ((is_b && at3) || (is_h && addr_lo[1]));

  assign ctrl.ext_byte   = is_b;
  assign ctrl.ext_half   = is_h;
  assign ctrl.ext_signed = signed_ld;
  assign ctrl.fault      = bad;
endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer
  import lane_align_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = NUM_LANES * LANE_W
)(
  input  steer_ctrl_t       ctrl,
  input  logic [BUS_W-1:0]  src,
  output logic [BUS_W-1:0]  dst
);
  logic [LANE_W-1:0] p0, p1, p2, p3, d0, d1, d2, d3;

  always_comb begin
    {p3, p2, p1, p0} = src;
    d0 = p0;
    d1 = ctrl.st_l1_from_l0 ? d0 : p1;
    d2 = ctrl.st_l2_from_l0 ? d0 : p2;
    d3 = ctrl.st_l3_from_l1 ? d1 : p3;   // second hop for offset 3
    dst = {d3, d2, d1, d0};
  end
endmodule

// File: rtl/lane_load_steer.sv
module lane_load_steer
  import lane_align_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = NUM_LANES * LANE_W
)(
  input  steer_ctrl_t       ctrl,
  input  logic [BUS_W-1:0]  src,
  output logic [BUS_W-1:0]  dst
);
  logic [LANE_W-1:0] d0, d1, d2, d3, q0, q1;
  logic              fill_b, fill_h;

  always_comb begin
    {d3, d2, d1, d0} = src;
    q1 = ctrl.ld_l1_from_l3 ? d3 : d1;
    q0 = ctrl.ld_l0_from_l1 ? q1 : (ctrl.ld_l0_from_l2 ? d2 : d0);
    fill_b = ctrl.ext_signed && q0[LANE_W-1];
    fill_h = ctrl.ext_signed && q1[LANE_W-1];
    if (ctrl.ext_byte)
      dst = {{(BUS_W-LANE_W){fill_b}}, q0};
    else if (ctrl.ext_half)
      dst = {{(BUS_W-2*LANE_W){fill_h}}, q1, q0};
    else
      dst = {d3, d2, q1, q0};
  end
endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import lane_align_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = NUM_LANES * LANE_W
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 is_store,
  input  logic [1:0]           size,
  input  logic [1:0]           addr_lo,
  input  logic                 signed_ld,
  input  logic [BUS_W-1:0]     cpu_wdata,
  input  logic [BUS_W-1:0]     bus_rdata,
  output logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     cpu_rdata,
  output logic [NUM_LANES-1:0] byte_sel,
  output logic                 misalign
);
  steer_ctrl_t      ctrl_d, ctrl_q;
  logic [BUS_W-1:0] wdata_q, rdata_q;

  lane_ctrl_decode u_dec (
    .is_store  (is_store),
    .size      (acc_size_e'(size)),
    .addr_lo   (addr_lo),
    .signed_ld (signed_ld),
    .ctrl      (ctrl_d)
  );

  // Capture stage: controls reset to the no-copy state
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (start) begin
      ctrl_q  <= ctrl_d;
      wdata_q <= cpu_wdata;
      rdata_q <= bus_rdata;
    end
  end

  lane_store_steer #(.LANE_W(LANE_W)) u_st (
    .ctrl (ctrl_q), .src (wdata_q), .dst (bus_wdata)
  );

  lane_load_steer #(.LANE_W(LANE_W)) u_ld (
    .ctrl (ctrl_q), .src (rdata_q), .dst (cpu_rdata)
  );

  assign byte_sel = ctrl_q.lane_en;
  assign misalign = ctrl_q.fault;

  // Strobe count is 0, 1, 2 or 4, never 3
  p_sel_count_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(byte_sel) != 3);

  p_misalign_r7: assert property (@(posedge clk) disable iff (rst)
    (start && size == 2'b01 && addr_lo[0]) |=> (misalign && byte_sel == '0));

  p_word_sel_r5: assert property (@(posedge clk) disable iff (rst)
    (start && size == 2'b10) |=> (byte_sel == '1 && !misalign));

  p_load_nocopy_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !is_store) |=> (bus_wdata == $past(cpu_wdata)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(byte_sel) && $stable(misalign) &&
                $stable(bus_wdata) && $stable(cpu_rdata)));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (byte_sel == '0 && !misalign && cpu_rdata == '0 && bus_wdata == '0));
endmodule

// File: tb/lane_align_unit_tb.sv
module lane_align_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_store = 1'b0;
  logic [1:0]  size = '0;
  logic [1:0]  addr_lo = '0;
  logic        signed_ld = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] bus_rdata = '0;
  logic [31:0] bus_wdata, cpu_rdata;
  logic [3:0]  byte_sel;
  logic        misalign;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  lane_align_unit u_dut (
    .clk (clk), .rst (rst), .start (start), .is_store (is_store),
    .size (size), .addr_lo (addr_lo), .signed_ld (signed_ld),
    .cpu_wdata (cpu_wdata), .bus_rdata (bus_rdata),
    .bus_wdata (bus_wdata), .cpu_rdata (cpu_rdata),
    .byte_sel (byte_sel), .misalign (misalign)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] f_sel(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'b00:   return 4'b0001 << off;
      2'b01:   return off[0] ? 4'b0000 : (off[1] ? 4'b1100 : 4'b0011);
      2'b10:   return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic f_err(input logic [1:0] sz, input logic [1:0] off);
    return (sz == 2'b11) || (sz == 2'b01 && off[0]);
  endfunction

  function automatic logic [31:0] f_mask(input logic [3:0] sel);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{sel[i]}};
    return m;
  endfunction

  function automatic logic [31:0] f_load(input logic [1:0] sz, input logic [1:0] off,
                                         input logic sg, input logic [31:0] rd);
    logic [31:0] s;
    s = rd >> (8 * off);
    case (sz)
      2'b00:   return sg ? {{24{s[7]}}, s[7:0]} : {24'h0, s[7:0]};
      2'b01:   return sg ? {{16{s[15]}}, s[15:0]} : {16'h0, s[15:0]};
      default: return rd;
    endcase
  endfunction

  task automatic run_op(input logic st, input logic [1:0] sz, input logic [1:0] off,
                        input logic sg, input logic [31:0] wd, input logic [31:0] rd);
    logic [3:0]  es;
    logic [31:0] m, hw, hr;
    logic [3:0]  hs;
    logic        he;
    @(negedge clk);
    is_store = st; size = sz; addr_lo = off; signed_ld = sg;
    cpu_wdata = wd; bus_rdata = rd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    es = f_sel(sz, off);
    chk("R1 byte_sel", {28'h0, byte_sel}, {28'h0, es});
    chk("R7 misalign", {31'h0, misalign}, {31'h0, f_err(sz, off)});
    if (!f_err(sz, off)) begin
      m = f_mask(es);
      if (st) begin
        if (sz == 2'b10) chk("R5 word store", bus_wdata, wd);
        else chk("R2 store lanes", bus_wdata & m, (wd << (8 * off)) & m);
      end else begin
        chk("R6 load keeps store bus", bus_wdata, wd);
        case (sz)
          2'b00:   chk("R3 byte load", cpu_rdata, f_load(sz, off, sg, rd));
          2'b01:   chk("R4 half load", cpu_rdata, f_load(sz, off, sg, rd));
          default: chk("R5 word load", cpu_rdata, rd);
        endcase
      end
    end
    // Hold: scramble inputs with start low
    hw = bus_wdata; hr = cpu_rdata; hs = byte_sel; he = misalign;
    is_store = ~st; size = ~sz; addr_lo = ~off; signed_ld = ~sg;
    cpu_wdata = ~wd; bus_rdata = ~rd;
    @(negedge clk);
    chk("R8 hold", {bus_wdata ^ hw} | {cpu_rdata ^ hr} | {27'h0, byte_sel ^ hs, misalign ^ he}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    cpu_wdata = 32'hDEAD_BEEF; bus_rdata = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset byte_sel", {28'h0, byte_sel}, 32'h0);
    chk("R9 reset misalign", {31'h0, misalign}, 32'h0);
    chk("R9 reset cpu_rdata", cpu_rdata, 32'h0);
    chk("R9 reset bus_wdata", bus_wdata, 32'h0);

    // Directed corners: chained offset-3 paths, sign bits set
    run_op(1'b1, 2'b00, 2'd3, 1'b0, 32'h0000_00A5, 32'h0);
    run_op(1'b0, 2'b00, 2'd3, 1'b1, 32'h1111_1111, 32'h80_00_00_00);
    run_op(1'b0, 2'b00, 2'd3, 1'b0, 32'h2222_2222, 32'hFF_00_00_00);
    run_op(1'b0, 2'b01, 2'd2, 1'b1, 32'h3333_3333, 32'h8001_7FFF);
    run_op(1'b0, 2'b01, 2'd0, 1'b1, 32'h4444_4444, 32'h0000_8000);
    run_op(1'b0, 2'b10, 2'd3, 1'b1, 32'h5555_5555, 32'h8765_4321);
    run_op(1'b1, 2'b01, 2'd3, 1'b0, 32'h0000_BEEF, 32'h0);
    run_op(1'b1, 2'b11, 2'd0, 1'b0, 32'h0000_BEEF, 32'h0);

    // Full sweep of direction, size, offset and signedness
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int sg = 0; sg < 2; sg++)
            run_op(st[0], sz[1:0], off[1:0], sg[0], $urandom, $urandom);

    // Constrained random
    for (int k = 0; k < 300; k++) begin
      logic [1:0] rsz;
      rsz = 2'($urandom_range(0, 9) < 9 ? $urandom_range(0, 2) : 3);
      run_op(1'($urandom), rsz, 2'($urandom), 1'($urandom), $urandom, $urandom);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule